// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache with Store Queue

This block sits between a 32-bit processor and main memory. It keeps one data word per line in a direct-mapped array, each line carrying a tag and a valid flag. A byte address is cut into three fields. The byte offset is the low two bits and is ignored for lookup. The line index comes next, and the tag takes the remaining high bits.

Every store is written through to memory. A store updates the line when it hits and is always placed in a small first-in first-out store queue, so no line ever holds data that memory lacks. The queue drains over a single request/grant memory port. A load miss takes that port ahead of any queued store, so the processor waits only on loads, or on a store that finds the queue full. A load miss whose word still sits in the queue is answered from the newest queued copy, never from stale memory.

The processor holds `cpu_req` with its address, direction and store data until it sees `cpu_ready` high in a cycle. A memory transfer completes in the cycle `mem_gnt` is high. For a read, the word on `mem_rdata` in that cycle is the answer.

Top module: `wt_cache`

## Requirements
- R1: Lookup uses index = addr[5:2] and tag = addr[31:6] (default 16 lines). The byte offset addr[1:0] is ignored, and every memory address issued has its two low bits at zero.
- R2: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first load of any address fetches from memory.
- R3: A load whose line is valid with a matching tag completes in the cycle it is presented, returns the stored word and issues no memory read.
- R4: A load miss with no queued copy drives a memory read (`mem_we` low). It completes in the grant cycle with `cpu_rdata` equal to `mem_rdata`, and the line takes the word and tag in that same cycle.
- R5: Two addresses that differ by a multiple of 64 bytes share a line, and loading one evicts the other.
- R6: A store is accepted in the cycle it is presented while the queue has room. A store hit updates the line, a store miss leaves the cache unchanged, and every accepted store reaches memory.
- R7: While the queue holds QDEPTH (default 4) entries, a new store is held with `cpu_ready` low until an entry drains.
- R8: A pending load miss owns the memory port ahead of queued stores. Stores drain only when no load miss is pending.
- R9: A load miss to a word with a queued store returns the newest queued data at once, installs it in the line and issues no memory read.
- R10: Queued stores reach memory in the order the processor issued them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | 1 = write from queue head, 0 = read for a miss |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Data of the queue head |
| mem_gnt | input | 1 | Memory completes the presented transfer this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt on a read |

## Verification
Two functions can land in the same cycle. A load miss can need the memory port while stores still wait in the queue, and a new store can enter the queue in the cycle the head store drains. The bench stalls grants so that stores pile up, then presents a load miss or a further store and releases the grants. It judges the result from the order of transfers seen on the memory port, the data returned to the processor against a reference memory updated on every accepted store, and the final contents of memory. A mixed load/store stream with varying grant latency over a 256-byte window forces conflicts, forwarding and full-queue stalls to overlap.

// File: rtl/wt_cache.sv
`timescale 1ns/1ps
module wt_cache #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 4,
  parameter int QDEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFS_W = $clog2(DATA_W / 8);
  localparam int WA_W  = ADDR_W - OFS_W;
  localparam int TAG_W = WA_W - INDEX_W;
  localparam int LINES = 1 << INDEX_W;
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q   [LINES];
  logic [DATA_W-1:0] line_q  [LINES];
  logic [WA_W-1:0]   qaddr_q [QDEPTH];
  logic [DATA_W-1:0] qdata_q [QDEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  wire [WA_W-1:0]    req_word = WA_W'(cpu_addr >> OFS_W);
  wire [INDEX_W-1:0] req_idx  = req_word[INDEX_W-1:0];
  wire [TAG_W-1:0]   req_tag  = req_word[WA_W-1 -: TAG_W];

  wire rd      = cpu_req & ~cpu_we;
  wire wr      = cpu_req & cpu_we;
  wire hit     = valid_q[req_idx] && (tag_q[req_idx] == req_tag);
  wire q_full  = (count_q == CNT_W'(QDEPTH));
  wire q_empty = (count_q == '0);

  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  always_comb begin
    int slot;
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int i = 0; i < QDEPTH; i++) begin
      slot = (int'(head_q) + i) % QDEPTH;
      if (i < int'(count_q) && qaddr_q[PTR_W'(slot)] == req_word) begin
        fwd_hit  = 1'b1;
        fwd_data = qdata_q[PTR_W'(slot)];
      end
    end
  end

  wire rd_mem  = rd & ~hit & ~fwd_hit;
  wire drain   = ~rd_mem & ~q_empty & mem_gnt;
  wire enq     = wr & ~q_full;
  wire install = rd & ~hit & (fwd_hit | mem_gnt);

  assign cpu_ready = (rd & (hit | fwd_hit | mem_gnt)) | enq;
  assign cpu_rdata = hit ? line_q[req_idx] : (fwd_hit ? fwd_data : mem_rdata);
  assign mem_req   = rd_mem | ~q_empty;
  assign mem_we    = ~rd_mem;
  assign mem_addr  = rd_mem ? {req_word, {OFS_W{1'b0}}} : {qaddr_q[head_q], {OFS_W{1'b0}}};
  assign mem_wdata = qdata_q[head_q];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (install) valid_q[req_idx] <= 1'b1;
      if (enq)     tail_q <= ptr_next(tail_q);
      if (drain)   head_q <= ptr_next(head_q);
      count_q <= count_q + CNT_W'(enq) - CNT_W'(drain);
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      tag_q[req_idx]  <= req_tag;
      line_q[req_idx] <= fwd_hit ? fwd_data : mem_rdata;
    end else if (enq && hit) begin
      line_q[req_idx] <= cpu_wdata;
    end
    if (enq) begin
      qaddr_q[tail_q] <= req_word;
      qdata_q[tail_q] <= cpu_wdata;
    end
  end
endmodule

module wt_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_gnt,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [CNT_W-1:0]  count
);
  wire load     = cpu_req && !cpu_we;
  wire fill_now = load && mem_req && !mem_we && mem_gnt;

  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr % (DATA_W / 8)) == 0);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !load) |-> !mem_req);

  p_fill_then_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && $past(fill_now) && cpu_addr == $past(cpu_addr)) |-> cpu_ready);

  p_fill_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_now |-> (cpu_ready && cpu_rdata == mem_rdata));

  p_store_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && count < CNT_W'(QDEPTH)) |-> cpu_ready);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && cpu_ready) |-> count < CNT_W'(QDEPTH));

  p_load_owns_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cpu_ready) |-> (mem_req && !mem_we));
endmodule

bind wt_cache wt_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QDEPTH(QDEPTH), .CNT_W($clog2(QDEPTH + 1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .count(count_q)
);

// File: tb/wt_cache_tb.sv
`timescale 1ns/1ps
module wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  wt_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_fail = 0, rd_cnt = 0, lat = 0, wcnt = 0;
  bit block = 1'b0, done = 1'b0;
  logic [31:0] mem_m [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];
  logic [31:0] log_addr [$];
  bit          log_we [$];

  function automatic logic [31:0] init_word(input logic [31:0] wa);
    return wa * 32'h9E3779B1 + 32'h0000_1234;
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_m.exists(a >> 2) ? mem_m[a >> 2] : init_word(a >> 2);
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_m.exists(a >> 2) ? ref_m[a >> 2] : init_word(a >> 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: grant decided just after the falling edge, transfer logged before the rising edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mem_req && !block && wcnt >= lat) begin
        mem_gnt = 1'b1; wcnt = 0;
      end else begin
        mem_gnt = 1'b0;
        if (mem_req) wcnt++;
      end
      mem_rdata = mem_rd(mem_addr);
      #5;
      if (mem_req && mem_gnt) begin
        log_addr.push_back(mem_addr);
        log_we.push_back(mem_we);
        if (mem_we) mem_m[mem_addr >> 2] = mem_wdata;
        else rd_cnt++;
      end
    end
  end

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a; cyc = 0;
    forever begin
      #8;
      if (cpu_ready) break;
      cyc++;
      @(negedge clk);
    end
    d = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] v, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = v; cyc = 0;
    forever begin
      #8;
      if (cpu_ready) break;
      cyc++;
      @(negedge clk);
    end
    ref_m[a >> 2] = v;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #2;
      if (!mem_req) return;
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #8;
    chk(!cpu_ready && !mem_req, "R2 idle after reset", {30'd0, mem_req, cpu_ready}, 32'd0);
  endtask

  task automatic t_miss_fill();
    logic [31:0] d; int cyc, r0, n;
    lat = 2; r0 = rd_cnt; n = log_addr.size();
    cpu_read(32'h0000_1003, d, cyc);
    chk(d == ref_rd(32'h1000), "R4 miss data", d, ref_rd(32'h1000));
    chk(cyc == 2, "R4 completes in grant cycle", cyc, 2);
    chk(rd_cnt == r0 + 1, "R2 first load fetches", rd_cnt, r0 + 1);
    chk(log_addr[n] == 32'h1000, "R1 aligned fetch address", log_addr[n], 32'h1000);
  endtask

  task automatic t_hit();
    logic [31:0] d; int cyc, r0;
    r0 = rd_cnt;
    cpu_read(32'h0000_1001, d, cyc);
    chk(cyc == 0, "R3 hit same cycle", cyc, 0);
    chk(d == ref_rd(32'h1000), "R3 hit data", d, ref_rd(32'h1000));
    chk(rd_cnt == r0, "R1 offset ignored, no fetch", rd_cnt, r0);
  endtask

  task automatic t_conflict();
    logic [31:0] d; int cyc, r0;
    r0 = rd_cnt;
    cpu_read(32'h0000_1040, d, cyc);
    chk(rd_cnt == r0 + 1 && d == ref_rd(32'h1040), "R5 alias miss", d, ref_rd(32'h1040));
    cpu_read(32'h0000_1000, d, cyc);
    chk(rd_cnt == r0 + 2, "R5 evicted line refetched", rd_cnt, r0 + 2);
    chk(d == ref_rd(32'h1000), "R5 refetch data", d, ref_rd(32'h1000));
    cpu_read(32'h0000_1004, d, cyc);
    cpu_read(32'h0000_1000, d, cyc);
    chk(cyc == 0 && rd_cnt == r0 + 3, "R1 neighbour index keeps line", cyc, 0);
  endtask

  task automatic t_store();
    logic [31:0] d; int cyc, r0;
    r0 = rd_cnt;
    cpu_write(32'h0000_1000, 32'hCAFE_0001, cyc);
    chk(cyc == 0, "R6 store accepted at once", cyc, 0);
    cpu_read(32'h0000_1000, d, cyc);
    chk(cyc == 0 && d == 32'hCAFE_0001, "R6 store hit updates line", d, 32'hCAFE_0001);
    wait_idle();
    chk(mem_rd(32'h1000) == 32'hCAFE_0001, "R6 store reaches memory", mem_rd(32'h1000), 32'hCAFE_0001);
    cpu_write(32'h0000_2000, 32'h0BAD_F00D, cyc);
    wait_idle();
    r0 = rd_cnt;
    cpu_read(32'h0000_2000, d, cyc);
    chk(rd_cnt == r0 + 1, "R6 store miss does not allocate", rd_cnt, r0 + 1);
    chk(d == 32'h0BAD_F00D, "R6 store miss data", d, 32'h0BAD_F00D);
  endtask

  task automatic t_full();
    int cyc, n;
    block = 1'b1; lat = 0; n = log_addr.size();
    for (int i = 0; i < 4; i++) begin
      cpu_write(32'h3000 + 32'(i * 4), 32'hA000_0000 + 32'(i), cyc);
      chk(cyc == 0, "R7 room in queue", cyc, 0);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h3010; cpu_wdata = 32'hA000_0004;
    for (int i = 0; i < 3; i++) begin
      #8;
      chk(!cpu_ready, "R7 full queue stalls store", {31'd0, cpu_ready}, 32'd0);
      @(negedge clk);
    end
    block = 1'b0;
    for (int i = 0; i < 20; i++) begin
      #8;
      if (cpu_ready) break;
      @(negedge clk);
    end
    chk(cpu_ready, "R7 store accepted after drain", {31'd0, cpu_ready}, 32'd1);
    ref_m[32'h3010 >> 2] = 32'hA000_0004;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    wait_idle();
    for (int i = 0; i < 5; i++)
      chk(log_we[n + i] && log_addr[n + i] == 32'h3000 + 32'(i * 4), "R10 drain order",
          log_addr[n + i], 32'h3000 + 32'(i * 4));
  endtask

  task automatic t_prio();
    logic [31:0] d; int cyc, n;
    block = 1'b1; lat = 0;
    cpu_write(32'h4000, 32'h1111_0000, cyc);
    cpu_write(32'h4004, 32'h1111_0004, cyc);
    n = log_addr.size();
    fork
      cpu_read(32'h5000, d, cyc);
      begin repeat (3) @(negedge clk); block = 1'b0; end
    join
    chk(!log_we[n] && log_addr[n] == 32'h5000, "R8 load miss served first", log_addr[n], 32'h5000);
    chk(d == ref_rd(32'h5000), "R4 data under pending stores", d, ref_rd(32'h5000));
    wait_idle();
    chk(log_we[n + 1] && log_addr[n + 1] == 32'h4000, "R10 first store after load", log_addr[n + 1], 32'h4000);
    chk(log_we[n + 2] && log_addr[n + 2] == 32'h4004, "R10 second store", log_addr[n + 2], 32'h4004);
  endtask

  task automatic t_fwd();
    logic [31:0] d; int cyc, r0;
    block = 1'b1; lat = 0;
    cpu_write(32'h6000, 32'h2222_0001, cyc);
    cpu_write(32'h6000, 32'h2222_0002, cyc);
    r0 = rd_cnt;
    cpu_read(32'h6002, d, cyc);
    chk(cyc == 0, "R9 forwarded load no stall", cyc, 0);
    chk(d == 32'h2222_0002, "R9 newest queued data", d, 32'h2222_0002);
    block = 1'b0;
    wait_idle();
    chk(rd_cnt == r0, "R9 no memory read", rd_cnt, r0);
    cpu_read(32'h6000, d, cyc);
    chk(cyc == 0 && d == 32'h2222_0002, "R9 line installed", d, 32'h2222_0002);
    chk(mem_rd(32'h6000) == 32'h2222_0002, "R10 last store wins in memory", mem_rd(32'h6000), 32'h2222_0002);
  endtask

  task automatic t_stream();
    logic [31:0] r, a, d; int cyc;
    r = 32'h1BAD_5EED;
    for (int i = 0; i < 400; i++) begin
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      a = 32'h8000 + ((r >> 4) & 32'hFC) + {30'd0, r[13:12]};
      lat = int'(r[9:8]) % 3;
      if (r[0]) cpu_write(a, r ^ 32'h5A5A_0000, cyc);
      else begin
        cpu_read(a, d, cyc);
        chk(d == ref_rd(a), "R4 stream load vs reference", d, ref_rd(a));
      end
    end
    wait_idle();
    foreach (ref_m[k])
      chk(mem_rd(k << 2) == ref_m[k], "R6 memory matches reference", mem_rd(k << 2), ref_m[k]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_miss_fill();
    t_hit();
    t_conflict();
    t_store();
    t_full();
    t_prio();
    t_fwd();
    t_stream();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule